// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial control bus. The bus has a clock line and a shared open-drain data line. Behind it sits a file of 74 byte-wide configuration registers, at addresses 00h to 49h. All registers are presented in parallel to the rest of the chip. A bus master writes registers with a device-address byte, a register-address byte and one or more data bytes. Within a transaction the register pointer advances by one after every data byte.

A read uses the combined format. The master first sends the device address with the direction bit clear, then the register address. It then issues a repeated start and the device address with the direction bit set. The slave returns bytes MSB first and keeps going while the master acknowledges each one. Both bus lines are synchronised into the system clock domain with two flops. Start, stop and clock edges are detected on the synchronised copies. The slave changes the data line only after a detected falling clock edge.

Several checks are built in. The device address is checked against a fixed pattern plus one strap pin. Register addresses above 49h are refused, and two address ranges are write-only. Register 49h may only be touched as the sole byte of a transaction.

Top module: `twi_cfg_slave`

## Requirements
- R1: A falling data line while the clock is high (start) resets the byte framing from any state, including the middle of a byte. A rising data line while the clock is high (stop) ends the transaction, and the slave leaves the data line released afterwards.
- R2: The device-address byte is acknowledged only if bits 7..3 are 0, bit 2 is 1 and bit 1 equals `strap_i`. Bit 0 selects read (1) or write (0). On any other device-address byte the slave gives no acknowledge and ignores the rest of the transaction.
- R3: A register-address byte from 00h to 49h is acknowledged and loads the register pointer. Any larger value is not acknowledged, and the rest of the transaction is ignored with no register changed.
- R4: In a write, each acknowledged data byte is stored at the pointer and appears on `regs_o[8*a +: 8]` for address a. The pointer then advances by one.
- R5: A write data byte that would land on 49h or above, other than the first data byte aimed at 49h, is not acknowledged and is discarded. The rest of the transaction is then ignored.
- R6: A transaction whose only data byte goes to 49h is acknowledged and stored. A read that starts at 49h returns its value.
- R7: A combined-format read is acknowledged at the read device address. The slave then drives the addressed register's value MSB first on the eight following clocks and releases the line for the master's acknowledge.
- R8: Each byte the master acknowledges is followed by the byte at the next address. A master no-acknowledge ends the read, and the slave releases the line before the stop.
- R9: Registers 06h..11h and 1Eh..47h are write-only. They store and output written data, but reads of them return 00h.
- R10: A read burst that advances onto 49h or beyond returns FFh for those bytes, because the slave leaves the line released.
- R11: While `rst_n` is low, all registers are 00h and the data line is released.
- R12: The slave changes its data-line drive only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Resolved state of the bus data line |
| strap_i | input | 1 | Board strap that selects device-address bit 1 |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| regs_o | output | 592 | All registers, address a at bits 8*a+7..8*a |

## Verification
A wrong internal state shows up at the ports no later than the next acknowledge slot. A bad frame count moves the acknowledge to the wrong clock, and the master sees it as a missing or misplaced low pulse on the data line. A bad pointer or bad range decoding shows up on `regs_o` as soon as the data byte's acknowledge slot opens. It also shows up on the data line during the next read-back byte. A write-only or boundary decode fault is therefore caught by pairing each write with a combined-format read of the same address, and with reads that cross 48h/49h.

// File: rtl/twi_cfg_slave.sv
module twi_cfg_slave #(
  parameter int NREG    = 74,
  parameter int WO_A_LO = 6,
  parameter int WO_A_HI = 17,
  parameter int WO_B_LO = 30,
  parameter int WO_B_HI = 71
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int AW = $clog2(NREG + 1);
  localparam logic [7:0]    LAST8 = 8'(NREG - 1);
  localparam logic [AW-1:0] LASTA = AW'(NREG - 1);
  localparam logic [AW-1:0] WAL = AW'(WO_A_LO);
  localparam logic [AW-1:0] WAH = AW'(WO_A_HI);
  localparam logic [AW-1:0] WBL = AW'(WO_B_LO);
  localparam logic [AW-1:0] WBH = AW'(WO_B_HI);
  localparam logic [5:0]    DEV_HI = 6'b000001;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_REG, S_WR, S_RD} st_t;

  logic [2:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_s, sda_d;
  logic scl_rise, scl_fall, start_c, stop_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  assign scl_s    = scl_p[1];
  assign scl_d    = scl_p[2];
  assign sda_s    = sda_p[1];
  assign sda_d    = sda_p[2];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  st_t           st;
  logic [3:0]    cnt;
  logic [7:0]    sr, tx, rd_data;
  logic [AW-1:0] ptr, rd_addr;
  logic [2:0]    bidx;
  logic          first, rw, mack, drive, reading;
  logic [7:0]    regf [NREG];

  assign reading  = (st == S_RD);
  assign bidx     = 3'd7 - cnt[2:0];
  assign sda_oe_o = drive;

  function automatic logic is_wo(input logic [AW-1:0] a);
    return (a >= WAL && a <= WAH) || (a >= WBL && a <= WBH);
  endfunction

  always_comb begin
    rd_addr = reading ? ptr + 1'b1 : ptr;
    if (rd_addr > LASTA || (rd_addr == LASTA && reading)) rd_data = 8'hFF;
    else if (is_wo(rd_addr))                               rd_data = 8'h00;
    else                                                   rd_data = regf[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      sr    <= '0;
      tx    <= '0;
      ptr   <= '0;
      first <= 1'b0;
      rw    <= 1'b0;
      mack  <= 1'b0;
      drive <= 1'b0;
      for (int i = 0; i < NREG; i++) regf[i] <= '0;
    end else if (start_c) begin
      st    <= S_DEV;
      cnt   <= '0;
      drive <= 1'b0;
    end else if (stop_c) begin
      st    <= S_IDLE;
      cnt   <= '0;
      drive <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (cnt < 4'd8)       sr   <= {sr[6:0], sda_s};
        else if (cnt == 4'd8) mack <= ~sda_s;
        if (cnt < 4'd9)       cnt  <= cnt + 4'd1;
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          case (st)
            S_DEV:
              if (sr[7:1] == {DEV_HI, strap_i}) begin
                drive <= 1'b1;
                rw    <= sr[0];
              end else st <= S_IDLE;
            S_REG:
              if (sr <= LAST8) begin
                drive <= 1'b1;
                ptr   <= sr[AW-1:0];
              end else st <= S_IDLE;
            S_WR:
              if (ptr < LASTA || (ptr == LASTA && first)) begin
                drive     <= 1'b1;
                regf[ptr] <= sr;
                first     <= 1'b0;
              end else st <= S_IDLE;
            default: drive <= 1'b0;
          endcase
        end else if (cnt == 4'd9) begin
          cnt   <= '0;
          drive <= 1'b0;
          case (st)
            S_DEV:
              if (rw) begin
                st    <= S_RD;
                tx    <= rd_data;
                drive <= ~rd_data[7];
              end else st <= S_REG;
            S_REG: begin
              st    <= S_WR;
              first <= 1'b1;
            end
            S_WR: ptr <= ptr + 1'b1;
            S_RD:
              if (mack) begin
                ptr   <= ptr + 1'b1;
                tx    <= rd_data;
                drive <= ~rd_data[7];
              end else st <= S_IDLE;
            default: st <= S_IDLE;
          endcase
        end else if (reading && cnt != 4'd0) begin
          drive <= ~tx[bidx];
        end
      end
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regf[g];
  end
endmodule

// File: rtl/twi_cfg_slave_chk.sv
module twi_cfg_slave_chk #(
  parameter int W = 592
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_s,
  input logic         scl_fall,
  input logic         start_c,
  input logic         stop_c,
  input logic         sda_oe,
  input logic         reading,
  input logic [3:0]   cnt,
  input logic [W-1:0] regs
);
  assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);

  assert_start_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (cnt == 4'd0 && !sda_oe));

  assert_ack_slot_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !reading) |-> (cnt == 4'd8 || cnt == 4'd9));

  assert_regs_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $past(scl_fall));

  always_comb
    if (!rst_n) assert_reset_state_R11: assert (!sda_oe);
endmodule

bind twi_cfg_slave twi_cfg_slave_chk #(.W(NREG*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_c(start_c), .stop_c(stop_c), .sda_oe(sda_oe_o),
  .reading(reading), .cnt(cnt), .regs(regs_o)
);

// File: tb/twi_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module twi_cfg_slave_tb_top;
  localparam int NREG = 74;
  localparam int Q    = 6;
  localparam logic [7:0] DW = 8'h06, DR = 8'h07;

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire  sda_line = m_sda & ~sda_oe;

  int checks = 0, fails = 0, viol = 0;
  bit done = 0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  twi_cfg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(1'b1), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  logic prev_oe = 0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && m_scl) viol++;
    prev_oe = sda_oe;
  end

  // stimulus: {register, written value, value expected on read-back}
  localparam logic [23:0] VT [8] = '{
    24'h00_A5_A5, 24'h06_3C_00, 24'h12_81_81, 24'h47_11_00,
    24'h1D_0F_0F, 24'h48_5A_5A, 24'h05_7E_7E, 24'h1E_C3_00};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmp_regs(input string req);
    int bad = -1;
    for (int i = 0; i < NREG; i++)
      if (bad < 0 && regs[i*8 +: 8] !== model[i]) bad = i;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, req, regs[bad*8 +: 8], model[bad]);
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    m_sda = 1; wq; m_scl = 1; wq; m_sda = 0; wq; m_scl = 0; wq;
  endtask

  task automatic bus_stop;
    m_sda = 0; wq; m_scl = 1; wq; m_sda = 1; wq;
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wq; m_scl = 1; wq; wq; m_scl = 0; wq;
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1; wq; m_scl = 1; wq; b = sda_line; wq; m_scl = 0; wq;
  endtask

  task automatic put_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit mack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~mack);
  endtask

  task automatic write1(input logic [7:0] a, input logic [7:0] d, input string req);
    bit ack;
    bus_start;
    put_byte(DW, ack); chk(ack, "R2", ack, 1);
    put_byte(a, ack);  chk(ack, "R3", ack, 1);
    put_byte(d, ack);  chk(ack, req, ack, 1);
    bus_stop;
    model[a] = d;
  endtask

  task automatic read_open(input logic [7:0] a);
    bit ack;
    bus_start;
    put_byte(DW, ack); chk(ack, "R7", ack, 1);
    put_byte(a, ack);  chk(ack, "R7", ack, 1);
    bus_start;
    put_byte(DR, ack); chk(ack, "R7", ack, 1);
  endtask

  initial begin
    logic [7:0] rd;
    bit ack;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11", sda_oe, 0);
    cmp_regs("R11");
    rst_n = 1;
    wq;

    // table walk: write then read back each vector
    for (int v = 0; v < 8; v++) begin
      write1(VT[v][23:16], VT[v][15:8], "R4");
      cmp_regs("R4");
      read_open(VT[v][23:16]);
      get_byte(rd, 1'b0);
      bus_stop;
      chk(rd === VT[v][7:0], (VT[v][7:0] != VT[v][15:8]) ? "R9" : "R7", rd, VT[v][7:0]);
    end

    // R2: wrong strap bit, and stray high bit
    bus_start;
    put_byte(8'h04, ack); chk(!ack, "R2", ack, 0);
    put_byte(8'h01, ack); chk(!ack, "R2", ack, 0);
    put_byte(8'hEE, ack); chk(!ack, "R2", ack, 0);
    bus_stop;
    bus_start;
    put_byte(8'h86, ack); chk(!ack, "R2", ack, 0);
    bus_stop;
    cmp_regs("R2");

    // R3: out-of-range register address
    bus_start;
    put_byte(DW, ack);    chk(ack, "R3", ack, 1);
    put_byte(8'h4A, ack); chk(!ack, "R3", ack, 0);
    put_byte(8'h77, ack); chk(!ack, "R3", ack, 0);
    bus_stop;
    bus_start;
    put_byte(DW, ack);
    put_byte(8'h80, ack); chk(!ack, "R3", ack, 0);
    bus_stop;
    cmp_regs("R3");

    // R1: start in the middle of a byte restarts framing
    bus_start;
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    bus_start;
    put_byte(DW, ack);    chk(ack, "R1", ack, 1);
    put_byte(8'h02, ack);
    put_byte(8'h21, ack); chk(ack, "R4", ack, 1);
    put_byte(8'h32, ack); chk(ack, "R4", ack, 1);
    put_byte(8'h43, ack); chk(ack, "R4", ack, 1);
    bus_stop;
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    model[2] = 8'h21; model[3] = 8'h32; model[4] = 8'h43;
    cmp_regs("R4");

    // R5: burst reaching 49h is refused
    bus_start;
    put_byte(DW, ack); put_byte(8'h46, ack);
    put_byte(8'hB6, ack); chk(ack, "R5", ack, 1);
    put_byte(8'hB7, ack); chk(ack, "R5", ack, 1);
    put_byte(8'hB8, ack); chk(ack, "R5", ack, 1);
    put_byte(8'hB9, ack); chk(!ack, "R5", ack, 0);
    put_byte(8'hBA, ack); chk(!ack, "R5", ack, 0);
    bus_stop;
    model[8'h46] = 8'hB6; model[8'h47] = 8'hB7; model[8'h48] = 8'hB8;
    cmp_regs("R5");

    // R6: lone write to 49h; second byte in same transaction refused (R5)
    write1(8'h49, 8'h9C, "R6");
    cmp_regs("R6");
    bus_start;
    put_byte(DW, ack); put_byte(8'h49, ack);
    put_byte(8'h3D, ack); chk(ack, "R6", ack, 1);
    put_byte(8'h4E, ack); chk(!ack, "R5", ack, 0);
    bus_stop;
    model[8'h49] = 8'h3D;
    cmp_regs("R5");
    read_open(8'h49);
    get_byte(rd, 1'b0);
    bus_stop;
    chk(rd === 8'h3D, "R6", rd, 8'h3D);

    // R8: read burst with auto-increment and release after no-ack
    read_open(8'h02);
    get_byte(rd, 1'b1); chk(rd === 8'h21, "R8", rd, 8'h21);
    get_byte(rd, 1'b1); chk(rd === 8'h32, "R8", rd, 8'h32);
    get_byte(rd, 1'b0); chk(rd === 8'h43, "R8", rd, 8'h43);
    wq;
    chk(sda_oe == 1'b0, "R8", sda_oe, 0);
    bus_stop;

    // R9 + R10: burst across write-only 47h, readable 48h, then 49h
    read_open(8'h47);
    get_byte(rd, 1'b1); chk(rd === 8'h00, "R9", rd, 0);
    get_byte(rd, 1'b1); chk(rd === 8'hB8, "R10", rd, 8'hB8);
    get_byte(rd, 1'b1); chk(rd === 8'hFF, "R10", rd, 8'hFF);
    get_byte(rd, 1'b0); chk(rd === 8'hFF, "R10", rd, 8'hFF);
    bus_stop;

    chk(viol == 0, "R12", viol, 0);

    // R11: reset clears the file
    rst_n = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    cmp_regs("R11");
    chk(sda_oe == 1'b0, "R11", sda_oe, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule